// File: doc/BRIEF.md
# Horizontal 2x Linear Interpolating Upscaler

This block doubles the horizontal resolution of a reduced-resolution video line. During active video it takes one YCbCr sample every second clock. For every input sample it produces two output samples, one per clock. The first is a copy of the input sample. The second is the rounded average of that sample and the next one on the same line. Each of the three channels is handled the same way, so a 2:2:2 stream comes out as 4:4:4. For example, a 352-sample line becomes 704 samples, and 320 and 384 become 640 and 768.

At the end of a line there is no following sample. The last interpolated position therefore repeats the final input sample, and nothing is read across the line boundary. A bypass input lets an already full-rate 4:4:4 stream pass through unchanged, with the same pipeline latency as the upscaling path. Lines carry an even number of samples in normal use. The bypass input is changed only while no line is in progress.

Top module: `h2x_upscaler`

## Requirements
- R1: While reset is asserted, and after it is released until the first output, outValid is 0 and outY, outCb and outCr are 0.
- R2: In upscale mode the input carries one valid sample every two clocks. Each input sample yields exactly two outputs, and outValid stays high on consecutive clocks from the first output of a line to its last.
- R3: Output position 2n of a line equals input sample n on all three channels.
- R4: Output position 2n+1 (n not the last sample) equals (sample n + sample n+1 + 1) >> 1 on each channel. It rounds odd sums upward and does not overflow when both samples are at full scale.
- R5: For a line of N input samples exactly 2N outputs appear, and position 2N-1 repeats sample N-1.
- R6: In upscale mode, a sample captured at clock edge k appears as its copy output after edge k+3.
- R7: With bypass high, each valid input appears once, unchanged, after edge k+3 when captured at edge k, and no interpolated output is produced.
- R8: inValid is ignored while inLine is low, in both modes: no output results.
- R9: Each line starts fresh. The outputs of a new line depend only on that line's samples, and a line of a single sample yields two copies of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | 1: pass full-rate 4:4:4 input through unchanged |
| inLine | input | 1 | High while the active part of a line is being delivered |
| inValid | input | 1 | Input sample strobe |
| inY | input | PIX_W | Input luma |
| inCb | input | PIX_W | Input blue-difference chroma |
| inCr | input | PIX_W | Input red-difference chroma |
| outValid | output | 1 | Output sample strobe |
| outY | output | PIX_W | Output luma |
| outCb | output | PIX_W | Output blue-difference chroma |
| outCr | output | PIX_W | Output red-difference chroma |

## Verification
The main line is built from a table of samples. Each neighbouring pair has channels with odd and even sums, equal values, full-scale pairs and values that fall or rise. This tells round-up apart from truncation, catches carry loss at full scale, and shows any swap of channels or of positions.

A two-sample line follows a long line directly. It shows whether the first midpoint of a line is taken from the previous line's residue. A one-sample line separates the end-of-line repeat from the normal interpolation. A bypass line of distinct samples checks, against the upscale path, that nothing is averaged and that the latency is the same. Strobes given while the line flag is low, and a reset in mid-line, show whether stray input or left-over state leaks to the output.

// File: rtl/h2x_pkg.sv
package h2x_pkg;
  // strobes from the sequencer to the datapath, one set per clock
  typedef struct packed {
    logic loadHeld;  // capture first sample of a line into the held register
    logic loadNext;  // capture the following sample into the next register
    logic shift;     // held <= next after the midpoint has been emitted
    logic emitCopy;  // output the held sample
    logic emitMid;   // output the rounded average of held and next
    logic emitRep;   // output the held sample again at end of line
    logic passIn;    // bypass: push the input into the delay line
  } h2x_ctl_t;
endpackage

// File: rtl/h2x_ctrl.sv
module h2x_ctrl
  import h2x_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bypass,
  input  logic     inLine,
  input  logic     inValid,
  output h2x_ctl_t ctl
);
  logic hasHeld, stCopy, stMid, stRep;
  logic accept, flush;

  always_comb begin
    accept       = inValid && inLine;
    // line closed with one sample still owed two outputs
    flush        = !bypass && hasHeld && !inLine && !stCopy && !stMid && !stRep;
    ctl.passIn   = accept && bypass;
    ctl.loadHeld = accept && !bypass && (!hasHeld || stRep);
    ctl.loadNext = accept && !bypass && hasHeld && !stRep;
    ctl.shift    = stMid;
    ctl.emitCopy = stCopy || flush;
    ctl.emitMid  = stMid;
    ctl.emitRep  = stRep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hasHeld <= 1'b0;
      stCopy  <= 1'b0;
      stMid   <= 1'b0;
      stRep   <= 1'b0;
    end else begin
      stCopy  <= ctl.loadNext;
      stMid   <= stCopy;
      stRep   <= flush;
      hasHeld <= ctl.loadHeld || (hasHeld && !stRep);
    end
  end

  // R2: a new sample never lands on the clock that emits the copy
  assert_half_rate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !bypass) |-> !stCopy);

  // R2: at most one output kind per clock
  assert_single_emit_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.emitCopy, ctl.emitMid, ctl.emitRep}));

  // R5: the end-of-line repeat drains the held sample
  assert_drain_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stRep && !accept) |=> !hasHeld);

  // R7: no interpolation activity in bypass
  assert_no_interp_bypass_R7: assert property (@(posedge clk) disable iff (!rstN)
    bypass |-> !(ctl.emitMid || ctl.emitRep || ctl.loadNext));
endmodule

// File: rtl/h2x_datapath.sv
module h2x_datapath
  import h2x_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  h2x_ctl_t                ctl,
  input  logic [PIX_W*NUM_CH-1:0] inPix,
  output logic                    outValid,
  output logic [PIX_W*NUM_CH-1:0] outPix
);
  localparam int BUS_W     = PIX_W * NUM_CH;
  localparam int BYP_DEPTH = 3;  // matches the upscale path latency

  logic [BUS_W-1:0] held, nxt, midPix;
  logic [BYP_DEPTH-1:0] pipeValid;
  logic [BUS_W-1:0] pipeData [BYP_DEPTH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [PIX_W:0] sum;
    assign sum = {1'b0, held[ch*PIX_W +: PIX_W]} + {1'b0, nxt[ch*PIX_W +: PIX_W]}
               + (PIX_W+1)'(1);
    assign midPix[ch*PIX_W +: PIX_W] = sum[PIX_W:1];

    // R4: the midpoint lies between its two neighbours
    assert_mid_between_R4: assert property (@(posedge clk) disable iff (!rstN)
      ctl.emitMid |=>
        ((outPix[ch*PIX_W +: PIX_W] >= $past(held[ch*PIX_W +: PIX_W])) &&
         (outPix[ch*PIX_W +: PIX_W] <= $past(nxt[ch*PIX_W +: PIX_W]))) ||
        ((outPix[ch*PIX_W +: PIX_W] >= $past(nxt[ch*PIX_W +: PIX_W])) &&
         (outPix[ch*PIX_W +: PIX_W] <= $past(held[ch*PIX_W +: PIX_W]))));
  end

  for (genvar s = 0; s < BYP_DEPTH; s++) begin : g_byp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipeValid[s] <= 1'b0;
        pipeData[s]  <= '0;
      end else if (s == 0) begin
        pipeValid[s] <= ctl.passIn;
        pipeData[s]  <= inPix;
      end else begin
        pipeValid[s] <= pipeValid[s-1];
        pipeData[s]  <= pipeData[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held <= '0;
      nxt  <= '0;
    end else begin
      if (ctl.loadHeld)   held <= inPix;
      else if (ctl.shift) held <= nxt;
      if (ctl.loadNext)   nxt  <= inPix;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPix   <= '0;
    end else if (pipeValid[BYP_DEPTH-1]) begin
      outValid <= 1'b1;
      outPix   <= pipeData[BYP_DEPTH-1];
    end else if (ctl.emitCopy || ctl.emitRep) begin
      outValid <= 1'b1;
      outPix   <= held;
    end else if (ctl.emitMid) begin
      outValid <= 1'b1;
      outPix   <= midPix;
    end else begin
      outValid <= 1'b0;
    end
  end

  // R7: bypass output never collides with an interpolated output
  assert_path_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    pipeValid[BYP_DEPTH-1] |-> !(ctl.emitCopy || ctl.emitMid || ctl.emitRep));
endmodule

// File: rtl/h2x_upscaler.sv
module h2x_upscaler
  import h2x_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bypass,
  input  logic             inLine,
  input  logic             inValid,
  input  logic [PIX_W-1:0] inY,
  input  logic [PIX_W-1:0] inCb,
  input  logic [PIX_W-1:0] inCr,
  output logic             outValid,
  output logic [PIX_W-1:0] outY,
  output logic [PIX_W-1:0] outCb,
  output logic [PIX_W-1:0] outCr
);
  localparam int NUM_CH = 3;
  localparam int BUS_W  = PIX_W * NUM_CH;

  h2x_ctl_t ctl;
  logic [BUS_W-1:0] inPix, outPix;

  assign inPix = {inY, inCb, inCr};
  assign outY  = outPix[2*PIX_W +: PIX_W];
  assign outCb = outPix[PIX_W +: PIX_W];
  assign outCr = outPix[0 +: PIX_W];

  h2x_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bypass  (bypass),
    .inLine  (inLine),
    .inValid (inValid),
    .ctl     (ctl)
  );

  h2x_datapath #(.PIX_W(PIX_W), .NUM_CH(NUM_CH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inPix    (inPix),
    .outValid (outValid),
    .outPix   (outPix)
  );
endmodule

// File: tb/sim_h2x_upscaler.sv
`timescale 1ns/1ps
module sim_h2x_upscaler;
  localparam int W = 8;
  localparam int MAXO = 64;
  localparam logic [23:0] VEC [8] = '{
    24'h10_80_80, 24'h21_81_7F, 24'hFF_FF_00, 24'hFE_FF_01,
    24'h00_01_FF, 24'h01_02_FE, 24'h7F_40_C0, 24'h80_41_C1
  };

  logic clk = 1'b0, rstN = 1'b0, bypass = 1'b0, inLine = 1'b0, inValid = 1'b0;
  logic [W-1:0] inY = '0, inCb = '0, inCr = '0;
  logic outValid;
  logic [W-1:0] outY, outCb, outCr;

  int cyc = 0, checks = 0, failures = 0, capN = 0, firstEdge = 0;
  bit done = 0;
  logic [23:0] cap [MAXO];
  int capCyc [MAXO];
  logic [23:0] line [16];

  always #4 clk = ~clk;

  h2x_upscaler #(.PIX_W(W)) u0 (
    .clk(clk), .rstN(rstN), .bypass(bypass), .inLine(inLine), .inValid(inValid),
    .inY(inY), .inCb(inCb), .inCr(inCr),
    .outValid(outValid), .outY(outY), .outCb(outCb), .outCr(outCr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && outValid && capN < MAXO) begin
      cap[capN] = {outY, outCb, outCr};
      capCyc[capN] = cyc;
      capN++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 50000) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 50000);
      report();
    end
  end

  function automatic logic [23:0] avgPix(input logic [23:0] a, input logic [23:0] b);
    logic [23:0] r;
    for (int c = 0; c < 3; c++)
      r[c*8 +: 8] = 8'((int'(a[c*8 +: 8]) + int'(b[c*8 +: 8]) + 1) / 2);
    return r;
  endfunction

  task automatic sendLine(input int n, input bit byp);
    capN = 0;
    @(negedge clk);
    bypass = byp;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) firstEdge = cyc + 1;
      inLine = 1'b1;
      inValid = 1'b1;
      {inY, inCb, inCr} = line[i];
      if (!byp) begin
        @(negedge clk);
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inLine = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic checkUp(input int n, input string tag);
    chk(capN == 2*n, {"R5 count ", tag}, capN, 2*n);
    if (n >= 2) chk(capCyc[0] == firstEdge + 3, {"R6 latency ", tag}, capCyc[0], firstEdge + 3);
    for (int j = 1; j < capN && j < 2*n; j++)
      chk(capCyc[j] == capCyc[0] + j, {"R2 contiguous ", tag}, capCyc[j], capCyc[0] + j);
    for (int i = 0; i < n && 2*i+1 < capN; i++) begin
      chk(cap[2*i] == line[i], {"R3 copy ", tag}, cap[2*i], line[i]);
      if (i < n-1)
        chk(cap[2*i+1] == avgPix(line[i], line[i+1]), {"R4 mid ", tag},
            cap[2*i+1], avgPix(line[i], line[i+1]));
      else
        chk(cap[2*i+1] == line[i], {"R5 repeat ", tag}, cap[2*i+1], line[i]);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1 valid in reset", outValid, 0);
    chk({outY, outCb, outCr} == 24'h0, "R1 data in reset", {outY, outCb, outCr}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0 && capN == 0, "R1 idle after reset", capN, 0);

    // main line walked from the vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) line[i] = VEC[i];
    sendLine(8, 1'b0);
    checkUp(8, "table");

    // R9: short line right after, must not borrow from the previous line
    line[0] = 24'hFF_00_FF; line[1] = 24'hFF_00_FE;
    sendLine(2, 1'b0);
    checkUp(2, "R9 fresh line");

    // R9 / R5: single-sample line gives two copies
    line[0] = 24'h5A_A5_3C;
    sendLine(1, 1'b0);
    checkUp(1, "R9 single");

    // R7: bypass
    for (int i = 0; i < 5; i++) line[i] = 24'h11_22_33 + 24'(i * 24'h05_0A_0F);
    sendLine(5, 1'b1);
    chk(capN == 5, "R7 bypass count", capN, 5);
    chk(capCyc[0] == firstEdge + 3, "R7 bypass latency", capCyc[0], firstEdge + 3);
    for (int i = 0; i < 5 && i < capN; i++)
      chk(cap[i] == line[i], "R7 bypass data", cap[i], line[i]);

    // R8: strobes with line flag low, both modes
    for (int m = 0; m < 2; m++) begin
      capN = 0;
      @(negedge clk);
      bypass = m[0];
      inLine = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        inValid = 1'b1;
        {inY, inCb, inCr} = 24'hAB_CD_EF;
      end
      @(negedge clk);
      inValid = 1'b0;
      repeat (8) @(negedge clk);
      chk(capN == 0, "R8 ignored strobes", capN, 0);
    end

    // R1: reset in mid-line clears outputs, next line is clean
    @(negedge clk);
    bypass = 1'b0;
    inLine = 1'b1;
    inValid = 1'b1;
    {inY, inCb, inCr} = 24'h44_44_44;
    @(negedge clk); inValid = 1'b0;
    @(negedge clk); inValid = 1'b1; {inY, inCb, inCr} = 24'h66_66_66;
    @(negedge clk); inValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 mid-line reset valid", outValid, 0);
    chk({outY, outCb, outCr} == 24'h0, "R1 mid-line reset data", {outY, outCb, outCr}, 0);
    inLine = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    line[0] = 24'h02_03_04; line[1] = 24'h05_05_05;
    sendLine(2, 1'b0);
    checkUp(2, "R1 after reset");

    report();
  end
endmodule